// File: doc/BRIEF.md
# Row-hit-first DRAM request scheduler

This block sits in front of a simple four-bank DRAM model. It holds a small queue of pending read requests, each naming a bank, a row and a column, and chooses which one to start next. Each bank remembers the one row that is open in its row buffer, or that the buffer is empty. Every start is classed as a row hit, an empty-buffer open or a row conflict. A per-bank busy counter then models the service time of that class.

Among the queued requests whose bank is idle, a request that hits the open row of its bank beats every request that does not. Inside each of those two classes the request that arrived first wins. Requests enter through a valid/ready handshake, and at most one request starts per cycle. Each bank has its own completion lane, which pulses for one cycle with the request's tag, column and access class when the access finishes.

Top module: `dram_hit_sched`

## Requirements
- R1: When any queued request targets an idle bank and matches that bank's open row, the request started is such a row hit, never a non-matching request.
- R2: Within the same class (all hits, or all non-hits), the queued request that was accepted earliest starts first, including across different banks.
- R3: An access is classed and reported on done_kind as 0 (hit) when the bank holds the requested row, 1 (empty) when the bank's buffer is empty, and 2 (conflict) when the bank holds another row.
- R4: Service time from start to completion is LAT_HIT=2, LAT_EMPTY=4 or LAT_CONF=6 cycles. A request accepted at clock edge A into an empty queue for an idle bank starts at edge A+1, and its completion is visible in the cycle after edge A+1+latency.
- R5: After any access the requested row stays open in that bank, so a following request to the same bank and row is a hit.
- R6: Each bank keeps its own open row, and requests to different banks with different rows are classed independently.
- R7: A bank whose access is in progress starts nothing new until it has completed. Requests to other, idle banks start meanwhile.
- R8: At most one request starts per cycle. When two banks become idle together with a queued hit each, their starts fall in consecutive cycles.
- R9: The queue holds 8 requests. req_ready is low while it is full, and a request offered while req_ready is low is dropped and never completes.
- R10: Each completion is a one-cycle pulse on done_valid[b] (lane b = bank b), carrying that request's tag on done_tag[b*TAG_W +: TAG_W], column on done_col[b*COL_W +: COL_W] and class on done_kind[b*2 +: 2], with exactly one pulse per accepted request.
- R11: Reset leaves the queue empty (req_ready high), no completion pending, every bank idle and every row buffer empty, so that the first access to each bank after reset is classed empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can take a request |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_tag | input | TAG_W | Identifier returned with the completion |
| done_valid | output | 2**BANK_W | Per-bank completion pulse |
| done_tag | output | 2**BANK_W*TAG_W | Per-bank completed tag |
| done_col | output | 2**BANK_W*COL_W | Per-bank completed column |
| done_kind | output | 2**BANK_W*2 | Per-bank access class (0 hit, 1 empty, 2 conflict) |

## Verification
On every cycle the assertions check the selection rules: no start goes to a busy bank, at most one start happens, a non-hit start only occurs with no eligible hit, and no eligible entry of the same class is older than the one chosen. They also check that an access leaves its row open, that an access to an empty buffer is classed empty, that completions last one cycle and that req_ready only drops on a full queue. Only the bench scenarios can show the end-to-end results. These are the exact service latencies for each class, the completion order that hit-first and age ordering produce across many queued requests, the dropping of a request offered while full, and the state left by a reset in the middle of a run.

// File: rtl/dhs_pkg.sv
package dhs_pkg;
  typedef enum logic [1:0] {
    KIND_HIT   = 2'd0,
    KIND_EMPTY = 2'd1,
    KIND_CONF  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/dhs_queue.sv
module dhs_queue #(
  parameter int DEPTH   = 8,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 8,
  parameter int COL_W   = 6,
  parameter int TAG_W   = 8,
  parameter int STAMP_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              push,
  input  logic [BANK_W-1:0]                 push_bank,
  input  logic [ROW_W-1:0]                  push_row,
  input  logic [COL_W-1:0]                  push_col,
  input  logic [TAG_W-1:0]                  push_tag,
  input  logic                              pop,
  input  logic [$clog2(DEPTH)-1:0]          pop_idx,
  output logic [DEPTH-1:0]                  ent_vld,
  output logic [DEPTH-1:0][BANK_W-1:0]      ent_bank,
  output logic [DEPTH-1:0][ROW_W-1:0]       ent_row,
  output logic [DEPTH-1:0][COL_W-1:0]       ent_col,
  output logic [DEPTH-1:0][TAG_W-1:0]       ent_tag,
  output logic [DEPTH-1:0][STAMP_W-1:0]     ent_stamp,
  output logic                              full
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]   vld_q, vld_d;
  logic [CNT_W-1:0]   count_q, count_d;
  logic [STAMP_W-1:0] stamp_q, stamp_d;
  logic [IDX_W-1:0]   free_idx;
  logic               free_found;

  // lowest free slot
  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !free_found) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (pop)                vld_d[pop_idx]  = 1'b0;
    if (push && free_found) vld_d[free_idx] = 1'b1;
    count_d = count_q;
    if (push && !pop)       count_d = count_q + CNT_W'(1);
    else if (!push && pop)  count_d = count_q - CNT_W'(1);
    stamp_d = push ? stamp_q + STAMP_W'(1) : stamp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      count_q <= '0;
      stamp_q <= '0;
    end else begin
      vld_q   <= vld_d;
      count_q <= count_d;
      stamp_q <= stamp_d;
    end
  end

  // payload storage, written only into the allocated slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = push && free_found && (free_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        ent_bank[g]  <= push_bank;
        ent_row[g]   <= push_row;
        ent_col[g]   <= push_col;
        ent_tag[g]   <= push_tag;
        ent_stamp[g] <= stamp_q;
      end
    end
  end

  assign ent_vld = vld_q;
  assign full    = (count_q == CNT_W'(DEPTH));
endmodule

// File: rtl/dhs_pick.sv
module dhs_pick #(
  parameter int DEPTH   = 8,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 8,
  parameter int STAMP_W = 16
) (
  input  logic [DEPTH-1:0]                  ent_vld,
  input  logic [DEPTH-1:0][BANK_W-1:0]      ent_bank,
  input  logic [DEPTH-1:0][ROW_W-1:0]       ent_row,
  input  logic [DEPTH-1:0][STAMP_W-1:0]     ent_stamp,
  input  logic [(1<<BANK_W)-1:0]            bank_idle,
  input  logic [(1<<BANK_W)-1:0]            bank_open_vld,
  input  logic [(1<<BANK_W)-1:0][ROW_W-1:0] bank_open_row,
  output logic                              pick_vld,
  output logic [$clog2(DEPTH)-1:0]          pick_idx
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int KEY_W = STAMP_W + 1;

  logic [DEPTH-1:0]            elig;
  logic [DEPTH-1:0][KEY_W-1:0] key;

  // per entry: eligible if its bank is idle; class bit 0 for a hit
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic hit;
    assign hit     = bank_open_vld[ent_bank[g]] && (bank_open_row[ent_bank[g]] == ent_row[g]);
    assign elig[g] = ent_vld[g] && bank_idle[ent_bank[g]];
    assign key[g]  = {~hit, ent_stamp[g]};
  end

  // smallest key: class first, then arrival stamp
  always_comb begin
    logic [KEY_W-1:0] best;
    best     = '0;
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig[i] && (!pick_vld || key[i] < best)) begin
        pick_vld = 1'b1;
        best     = key[i];
        pick_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dhs_bank.sv
module dhs_bank
  import dhs_pkg::*;
#(
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int TAG_W     = 8,
  parameter int LAT_HIT   = 2,
  parameter int LAT_EMPTY = 4,
  parameter int LAT_CONF  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [ROW_W-1:0] issue_row,
  input  logic [COL_W-1:0] issue_col,
  input  logic [TAG_W-1:0] issue_tag,
  output logic             idle,
  output logic             open_vld,
  output logic [ROW_W-1:0] open_row,
  output acc_kind_e        issue_kind,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag,
  output logic [COL_W-1:0] done_col,
  output acc_kind_e        done_kind
);
  localparam int LAT_A   = (LAT_HIT > LAT_EMPTY) ? LAT_HIT : LAT_EMPTY;
  localparam int LAT_MAX = (LAT_A > LAT_CONF) ? LAT_A : LAT_CONF;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  logic             open_vld_q, open_vld_d;
  logic [ROW_W-1:0] open_row_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [TAG_W-1:0] tag_q;
  logic [COL_W-1:0] col_q;
  acc_kind_e        kind_q;
  logic [CNT_W-1:0] lat;

  always_comb begin
    if (!open_vld_q)                  issue_kind = KIND_EMPTY;
    else if (open_row_q == issue_row) issue_kind = KIND_HIT;
    else                              issue_kind = KIND_CONF;
    case (issue_kind)
      KIND_HIT:   lat = CNT_W'(LAT_HIT);
      KIND_EMPTY: lat = CNT_W'(LAT_EMPTY);
      default:    lat = CNT_W'(LAT_CONF);
    endcase
  end

  always_comb begin
    open_vld_d = open_vld_q;
    cnt_d      = cnt_q;
    if (issue) begin
      open_vld_d = 1'b1;
      cnt_d      = lat;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
    done_d = !issue && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_vld_q <= 1'b0;
      cnt_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      open_vld_q <= open_vld_d;
      cnt_q      <= cnt_d;
      done_q     <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (issue) begin
      open_row_q <= issue_row;
      tag_q      <= issue_tag;
      col_q      <= issue_col;
      kind_q     <= issue_kind;
    end
  end

  assign idle       = (cnt_q == '0);
  assign open_vld   = open_vld_q;
  assign open_row   = open_row_q;
  assign done_valid = done_q;
  assign done_tag   = tag_q;
  assign done_col   = col_q;
  assign done_kind  = kind_q;
endmodule

// File: rtl/dram_hit_sched.sv
module dram_hit_sched
  import dhs_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int DEPTH     = 8,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int TAG_W     = 8,
  parameter int STAMP_W   = 16,
  parameter int LAT_HIT   = 2,
  parameter int LAT_EMPTY = 4,
  parameter int LAT_CONF  = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [BANK_W-1:0]              req_bank,
  input  logic [ROW_W-1:0]               req_row,
  input  logic [COL_W-1:0]               req_col,
  input  logic [TAG_W-1:0]               req_tag,
  output logic [(1<<BANK_W)-1:0]         done_valid,
  output logic [(1<<BANK_W)*TAG_W-1:0]   done_tag,
  output logic [(1<<BANK_W)*COL_W-1:0]   done_col,
  output logic [(1<<BANK_W)*2-1:0]       done_kind
);
  localparam int NB    = 1 << BANK_W;
  localparam int IDX_W = $clog2(DEPTH);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic                          q_full, push;
  logic [DEPTH-1:0]              ent_vld;
  logic [DEPTH-1:0][BANK_W-1:0]  ent_bank;
  logic [DEPTH-1:0][ROW_W-1:0]   ent_row;
  logic [DEPTH-1:0][COL_W-1:0]   ent_col;
  logic [DEPTH-1:0][TAG_W-1:0]   ent_tag;
  logic [DEPTH-1:0][STAMP_W-1:0] ent_stamp;
  logic                          pick_vld;
  logic [IDX_W-1:0]              pick_idx;
  logic [ROW_W-1:0]              pick_row;
  logic [COL_W-1:0]              pick_col;
  logic [TAG_W-1:0]              pick_tag;
  logic [BANK_W-1:0]             pick_bank;

  logic [NB-1:0]                 bank_idle, bank_open_vld, bank_issue;
  logic [NB-1:0][ROW_W-1:0]      bank_open_row;
  acc_kind_e                     bank_kind [NB];

  assign req_ready = rst_int_n && !q_full;
  assign push      = req_valid && req_ready;

  dhs_queue #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .COL_W(COL_W), .TAG_W(TAG_W), .STAMP_W(STAMP_W)
  ) u_queue (
    .clk(clk), .rst_n(rst_int_n),
    .push(push), .push_bank(req_bank), .push_row(req_row),
    .push_col(req_col), .push_tag(req_tag),
    .pop(pick_vld), .pop_idx(pick_idx),
    .ent_vld(ent_vld), .ent_bank(ent_bank), .ent_row(ent_row),
    .ent_col(ent_col), .ent_tag(ent_tag), .ent_stamp(ent_stamp),
    .full(q_full)
  );

  dhs_pick #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .STAMP_W(STAMP_W)
  ) u_pick (
    .ent_vld(ent_vld), .ent_bank(ent_bank), .ent_row(ent_row),
    .ent_stamp(ent_stamp), .bank_idle(bank_idle),
    .bank_open_vld(bank_open_vld), .bank_open_row(bank_open_row),
    .pick_vld(pick_vld), .pick_idx(pick_idx)
  );

  assign pick_row  = ent_row[pick_idx];
  assign pick_col  = ent_col[pick_idx];
  assign pick_tag  = ent_tag[pick_idx];
  assign pick_bank = ent_bank[pick_idx];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic      dv;
    acc_kind_e dk;
    assign bank_issue[b] = pick_vld && (pick_bank == BANK_W'(b));

    dhs_bank #(
      .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W),
      .LAT_HIT(LAT_HIT), .LAT_EMPTY(LAT_EMPTY), .LAT_CONF(LAT_CONF)
    ) u_bank (
      .clk(clk), .rst_n(rst_int_n),
      .issue(bank_issue[b]), .issue_row(pick_row),
      .issue_col(pick_col), .issue_tag(pick_tag),
      .idle(bank_idle[b]), .open_vld(bank_open_vld[b]),
      .open_row(bank_open_row[b]), .issue_kind(bank_kind[b]),
      .done_valid(dv), .done_tag(done_tag[b*TAG_W +: TAG_W]),
      .done_col(done_col[b*COL_W +: COL_W]), .done_kind(dk)
    );

    assign done_valid[b]       = dv;
    assign done_kind[b*2 +: 2] = dk;
  end
endmodule

// File: rtl/dhs_chk.sv
module dhs_chk
  import dhs_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int DEPTH   = 8,
  parameter int ROW_W   = 8,
  parameter int STAMP_W = 16
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              req_ready,
  input logic [DEPTH-1:0]                  ent_vld,
  input logic [DEPTH-1:0][BANK_W-1:0]      ent_bank,
  input logic [DEPTH-1:0][ROW_W-1:0]       ent_row,
  input logic [DEPTH-1:0][STAMP_W-1:0]     ent_stamp,
  input logic [(1<<BANK_W)-1:0]            bank_idle,
  input logic [(1<<BANK_W)-1:0]            bank_open_vld,
  input logic [(1<<BANK_W)-1:0][ROW_W-1:0] bank_open_row,
  input logic [(1<<BANK_W)-1:0]            bank_issue,
  input acc_kind_e                         bank_kind [1<<BANK_W],
  input logic [$clog2(DEPTH)-1:0]          pick_idx,
  input logic [ROW_W-1:0]                  pick_row,
  input logic [(1<<BANK_W)-1:0]            done_valid
);
  localparam int NB = 1 << BANK_W;

  logic any_issue, picked_hit, any_elig_hit, older_same;

  always_comb begin
    any_issue  = |bank_issue;
    picked_hit = 1'b0;
    for (int b = 0; b < NB; b++)
      if (bank_issue[b] && bank_kind[b] == KIND_HIT) picked_hit = 1'b1;
    any_elig_hit = 1'b0;
    older_same   = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      logic el, ht;
      el = ent_vld[j] && bank_idle[ent_bank[j]];
      ht = bank_open_vld[ent_bank[j]] && bank_open_row[ent_bank[j]] == ent_row[j];
      if (el && ht) any_elig_hit = 1'b1;
      if (el && (ht == picked_hit) && ent_stamp[j] < ent_stamp[pick_idx]) older_same = 1'b1;
    end
  end

  AST_HIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (any_issue && !picked_hit) |-> !any_elig_hit); // R1
  AST_OLDEST_IN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    any_issue |-> !older_same); // R2
  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_issue)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> ($countones(ent_vld) == DEPTH)); // R9

  for (genvar b = 0; b < NB; b++) begin : g_chk
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      bank_issue[b] |-> bank_idle[b]); // R7
    AST_ROW_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      bank_issue[b] |=> (bank_open_vld[b] && bank_open_row[b] == $past(pick_row))); // R5
    AST_EMPTY_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_issue[b] && !bank_open_vld[b]) |-> (bank_kind[b] == KIND_EMPTY)); // R3
    AST_ONE_CYCLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid[b] |=> !done_valid[b]); // R10
  end
endmodule

bind dram_hit_sched dhs_chk #(
  .BANK_W(BANK_W), .DEPTH(DEPTH), .ROW_W(ROW_W), .STAMP_W(STAMP_W)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .req_ready(req_ready),
  .ent_vld(ent_vld), .ent_bank(ent_bank), .ent_row(ent_row),
  .ent_stamp(ent_stamp), .bank_idle(bank_idle),
  .bank_open_vld(bank_open_vld), .bank_open_row(bank_open_row),
  .bank_issue(bank_issue), .bank_kind(bank_kind),
  .pick_idx(pick_idx), .pick_row(pick_row), .done_valid(done_valid)
);

// File: tb/dram_hit_sched_test.sv
module dram_hit_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int TW = 8;
  localparam int CW = 6;
  localparam logic [1:0] K_HIT = 2'd0, K_EMPTY = 2'd1, K_CONF = 2'd2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic [1:0]      req_bank;
  logic [7:0]      req_row;
  logic [CW-1:0]   req_col;
  logic [TW-1:0]   req_tag;
  logic [NB-1:0]   done_valid;
  logic [NB*TW-1:0] done_tag;
  logic [NB*CW-1:0] done_col;
  logic [NB*2-1:0]  done_kind;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_hit_sched uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_tag(req_tag),
    .done_valid(done_valid), .done_tag(done_tag), .done_col(done_col),
    .done_kind(done_kind)
  );

  typedef struct packed {
    logic [TW-1:0] tag;
    logic [1:0]    kind;
    logic [CW-1:0] col;
  } exp_t;

  exp_t expq [NB][$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   cyc      = 0;
  int   acc_cyc  [256];
  int   done_cyc [256];
  logic [NB-1:0] prev_done = '0;
  bit   mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic expect_done(input int b, input int tag, input logic [1:0] kind);
    exp_t e;
    e.tag  = TW'(tag);
    e.kind = kind;
    e.col  = CW'(tag);
    expq[b].push_back(e);
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input int b, input int row, input int tag);
    req_valid = 1'b1;
    req_bank  = 2'(b);
    req_row   = 8'(row);
    req_col   = CW'(tag);
    req_tag   = TW'(tag);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    acc_cyc[tag] = cyc;
    req_valid = 1'b0;
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: per-bank expected completions in order (R3, R10)
  always @(negedge clk) begin
    if (mon_on) begin
      for (int b = 0; b < NB; b++) begin
        if (prev_done[b] && done_valid[b])
          chk(1'b0, $sformatf("R10 bank %0d done_valid high two cycles: act 1 exp 0", b));
        if (done_valid[b]) begin
          logic [TW-1:0] at;
          logic [1:0]    ak;
          logic [CW-1:0] ac;
          at = done_tag[b*TW +: TW];
          ak = done_kind[b*2 +: 2];
          ac = done_col[b*CW +: CW];
          done_cyc[at] = cyc;
          if (expq[b].size() == 0) begin
            chk(1'b0, $sformatf("R9 bank %0d unexpected completion tag %0d: act 1 exp none", b, at));
          end else begin
            exp_t e;
            e = expq[b].pop_front();
            chk(at == e.tag && ak == e.kind && ac == e.col,
                $sformatf("R3/R10 bank %0d: act tag %0d kind %0d col %0d exp tag %0d kind %0d col %0d",
                          b, at, ak, ac, e.tag, e.kind, e.col));
          end
        end
      end
      prev_done = done_valid;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired: act running exp finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin acc_cyc[i] = -1; done_cyc[i] = -1; end
    rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_row = '0; req_col = '0; req_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_wait(4);
    mon_on = 1'b1;
    // R11 reset state
    chk(req_ready == 1'b1, $sformatf("R11 ready after reset: act %0d exp 1", req_ready));
    chk(done_valid == '0, $sformatf("R11 done after reset: act %0h exp 0", done_valid));

    // R4 + R11: first access to bank0 is empty, latency 4
    expect_done(0, 1, K_EMPTY); send(0, 5, 1); idle_wait(12);
    chk(done_cyc[1] - acc_cyc[1] == 5, $sformatf("R4 empty latency: act %0d exp 5", done_cyc[1] - acc_cyc[1]));
    // R4 + R5: same row again is a hit, latency 2
    expect_done(0, 2, K_HIT); send(0, 5, 2); idle_wait(12);
    chk(done_cyc[2] - acc_cyc[2] == 3, $sformatf("R4 hit latency: act %0d exp 3", done_cyc[2] - acc_cyc[2]));
    // R4 + R3: other row is a conflict, latency 6
    expect_done(0, 3, K_CONF); send(0, 7, 3); idle_wait(12);
    chk(done_cyc[3] - acc_cyc[3] == 7, $sformatf("R4 conflict latency: act %0d exp 7", done_cyc[3] - acc_cyc[3]));

    // R1 + R2: hits (12,14) jump ahead of older non-hits (11,13)
    expect_done(0, 10, K_CONF);
    expect_done(0, 12, K_HIT);
    expect_done(0, 14, K_HIT);
    expect_done(0, 11, K_CONF);
    expect_done(0, 13, K_CONF);
    send(0, 9, 10); send(0, 12, 11); send(0, 9, 12); send(0, 14, 13); send(0, 9, 14);
    idle_wait(40);
    chk(done_cyc[12] < done_cyc[11], $sformatf("R1 hit before older conflict: act %0d exp < %0d", done_cyc[12], done_cyc[11]));

    // R6 + R7: two banks with different rows run side by side
    expect_done(2, 20, K_EMPTY); expect_done(3, 21, K_EMPTY);
    expect_done(2, 22, K_HIT);   expect_done(3, 23, K_HIT);
    send(2, 4, 20); send(3, 8, 21); send(2, 4, 22); send(3, 8, 23);
    idle_wait(20);
    chk(done_cyc[21] - done_cyc[20] == 1, $sformatf("R7 other bank not held: act %0d exp 1", done_cyc[21] - done_cyc[20]));
    chk(done_cyc[23] - done_cyc[22] == 1, $sformatf("R6 independent hits: act %0d exp 1", done_cyc[23] - done_cyc[22]));

    // R8 + R2: banks 0 and 1 free up together, older hit starts one cycle earlier
    expect_done(0, 30, K_CONF); expect_done(0, 32, K_HIT);
    expect_done(1, 31, K_EMPTY); expect_done(1, 33, K_HIT);
    send(0, 40, 30); send(0, 40, 32); send(1, 70, 31); send(1, 70, 33);
    idle_wait(25);
    chk(done_cyc[33] - done_cyc[32] == 1, $sformatf("R8 starts one per cycle, R2 older first: act %0d exp 1", done_cyc[33] - done_cyc[32]));

    // R9: fill the queue behind a run of conflicts on bank3
    expect_done(3, 40, K_CONF); send(3, 90, 40);
    for (int t = 41; t <= 49; t++) begin
      expect_done(3, t, K_CONF);
      send(3, 59 + t, t);
    end
    chk(req_ready == 1'b0, $sformatf("R9 ready when full: act %0d exp 0", req_ready));
    // offered while full: must be dropped (would be a hit on row 108 if kept)
    req_valid = 1'b1; req_bank = 2'd3; req_row = 8'd108; req_col = CW'(50); req_tag = TW'(50);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, $sformatf("R9 still full: act %0d exp 0", req_ready));
    idle_wait(12);
    chk(req_ready == 1'b1, $sformatf("R9 ready after a slot frees: act %0d exp 1", req_ready));
    idle_wait(80);
    chk(done_cyc[50] == -1, $sformatf("R9 dropped request completed: act %0d exp -1", done_cyc[50]));

    // R11: reset mid-run clears open rows
    rst_n = 1'b0; idle_wait(2); rst_n = 1'b1; idle_wait(4);
    chk(req_ready == 1'b1 && done_valid == '0,
        $sformatf("R11 after second reset: act ready %0d done %0h exp 1 0", req_ready, done_valid));
    expect_done(0, 60, K_EMPTY); expect_done(0, 61, K_HIT);
    send(0, 40, 60); send(0, 40, 61);
    idle_wait(20);

    for (int b = 0; b < NB; b++)
      chk(expq[b].size() == 0, $sformatf("R10 bank %0d missing completions: act %0d exp 0", b, expq[b].size()));

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule